// File: doc/BRIEF.md
# Configuration Clear and Start Sequencer

This block decides when a programmable device may begin loading its configuration. An active-low restart request forces the configuration memory to be wiped. For as long as the request is held, a clear engine sweeps a parameterized address range again and again. When the request is released, the engine runs one more complete pass. The block pulls the shared open-drain INIT line low while any of this is in progress.

After that final pass the block lets go of INIT. It then watches the sensed, wired-AND value of the line, so any other device, or an external driver, that holds INIT low stalls the start. Once the line reads high, the block captures the mode-select pins. A device strapped as master adds a further settling delay, so that every slave on a daisy chain has seen INIT high. The block then raises a one-cycle start pulse and holds a ready level and the captured mode until the next restart request. Both asynchronous inputs, the restart request and the sensed INIT line, pass through two-flop synchronizers.

Top module: `cfg_start_seq`

## Requirements
- R1: While rst_ni is low, ready_o=0, start_o=0, mode_o=0, init_drive_lo_o=1, clr_we_o=1 and clr_addr_o=0. When reset is released, one clear pass starts at address 0.
- R2: While restart_ni is low, clr_we_o stays high and clr_addr_o steps by one every cycle. After address CLR_DEPTH-1 it returns to 0, so the sweep repeats.
- R3: When restart_ni is low, init_drive_lo_o is high from the third clock edge on, and it stays high while the request persists.
- R4: After restart_ni returns high, the last clear activity is exactly one unbroken pass over addresses 0 to CLR_DEPTH-1. After that pass, clr_we_o goes low.
- R5: If restart_ni is sampled low during the final pass, the pass is abandoned and clr_addr_o restarts from 0. This also holds in the cycle that would have completed the pass. In that case init_drive_lo_o stays high and no start follows.
- R6: After clearing, init_drive_lo_o=0. While init_sense_i is low, no start pulse, no ready level and no clear write occur.
- R7: mode_o takes the value of mode_i when the sensed INIT line is seen high. Later changes on mode_i have no effect on mode_o while ready_o is high.
- R8: With master_i=0, start_o is high three clock edges after init_sense_i rises: two synchronizer stages plus one state register.
- R9: With master_i=1, start_o comes exactly WAIT_CYC cycles later than it does with master_i=0.
- R10: start_o lasts exactly one cycle. ready_o rises with it and then stays high.
- R11: A restart request while the block is waiting or ready drops ready_o, drives INIT low and resumes clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_ni | input | 1 | Asynchronous active-low configuration restart request |
| init_sense_i | input | 1 | Sensed level of the shared open-drain INIT line |
| master_i | input | 1 | Strap: 1 selects master behaviour (extra settling wait) |
| mode_i | input | MODE_W | Mode-select pins, captured when INIT is seen high |
| init_drive_lo_o | output | 1 | 1 pulls the shared INIT line low |
| clr_we_o | output | 1 | Clear write enable to the configuration memory |
| clr_addr_o | output | ADDR_W | Clear address |
| start_o | output | 1 | One-cycle pulse: loading may begin |
| ready_o | output | 1 | Held high in the ready-to-configure state |
| mode_o | output | MODE_W | Captured configuration mode |

## Verification
The sharp collision is a restart request that reaches the state register in the same cycle in which the final clear pass writes its last address. Completion and abort then compete, and abort has to win. The bench provokes this by driving the request low while the clear address is three below the end. That offset accounts for the two synchronizer stages and the sweep register. The bench then judges the outcome at the ports: the address must be back at 0 with INIT still driven low, and after the request is released a complete, unbroken pass must follow.

// File: rtl/cfg_start_pkg.sv
package cfg_start_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_FINAL,
    ST_WAIT_INIT,
    ST_MWAIT,
    ST_READY
  } seq_state_e;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int unsigned   W       = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/cfg_clear_sweep.sv
module cfg_clear_sweep #(
  parameter int unsigned DEPTH = 48,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  addr_q <= '0;
    else if (!run_i || restart_i || addr_q == LAST) addr_q <= '0;
    else                                          addr_q <= addr_q + 1'b1;
  end

  assign we_o   = run_i;
  assign addr_o = addr_q;
  assign last_o = run_i && (addr_q == LAST);

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && addr_q == LAST) |=> (addr_o == '0))
    else $error("clear sweep did not wrap");
endmodule

// File: rtl/cfg_delay_cnt.sv
module cfg_delay_cnt #(
  parameter int unsigned CYCLES = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'((CYCLES == 0) ? 0 : CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!busy_i)         cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = busy_i && (cnt_q == LAST);

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cnt_q <= LAST))
    else $error("master wait counter overran");
endmodule

// File: rtl/cfg_start_seq.sv
module cfg_start_seq
  import cfg_start_pkg::*;
#(
  parameter int unsigned CLR_DEPTH = 48,
  parameter int unsigned ADDR_W    = (CLR_DEPTH > 1) ? $clog2(CLR_DEPTH) : 1,
  parameter int unsigned MODE_W    = 3,
  parameter int unsigned WAIT_CYC  = 25000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_ni,
  input  logic              init_sense_i,
  input  logic              master_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              init_drive_lo_o,
  output logic              clr_we_o,
  output logic [ADDR_W-1:0] clr_addr_o,
  output logic              start_o,
  output logic              ready_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam bit HAS_WAIT = (WAIT_CYC != 0);

  seq_state_e state_q, state_d;
  logic rs, init_s;
  logic clr_run, clr_rst, clr_last, wait_done;
  logic start_q;
  logic [MODE_W-1:0] mode_q;

  // bit0 = restart (idles released), bit1 = INIT sense (idles low)
  cfg_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({init_sense_i, restart_ni}),
    .q_o   ({init_s, rs})
  );

  assign clr_run = (state_q == ST_HOLD) || (state_q == ST_FINAL);
  // fresh sweep on entry to the final pass and on abort of it
  assign clr_rst = ((state_q == ST_HOLD) && rs) || ((state_q == ST_FINAL) && !rs);

  cfg_clear_sweep #(.DEPTH(CLR_DEPTH), .AW(ADDR_W)) u_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (clr_run),
    .restart_i(clr_rst),
    .we_o     (clr_we_o),
    .addr_o   (clr_addr_o),
    .last_o   (clr_last)
  );

  cfg_delay_cnt #(.CYCLES(WAIT_CYC)) u_mwait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(state_q == ST_MWAIT),
    .done_o(wait_done)
  );

  always_comb begin
    state_d = state_q;
    if (!rs) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:      state_d = ST_FINAL;
        ST_FINAL:     if (clr_last) state_d = ST_WAIT_INIT;
        ST_WAIT_INIT: if (init_s) state_d = (master_i && HAS_WAIT) ? ST_MWAIT : ST_READY;
        ST_MWAIT:     if (wait_done) state_d = ST_READY;
        ST_READY:     state_d = ST_READY;
        default:      state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FINAL;
      start_q <= 1'b0;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= (state_d == ST_READY) && (state_q != ST_READY);
      if (state_q == ST_WAIT_INIT && init_s && rs) mode_q <= mode_i;
    end
  end

  assign init_drive_lo_o = clr_run;
  assign start_o         = start_q;
  assign ready_o         = (state_q == ST_READY);
  assign mode_o          = mode_q;

  p_hold_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs |=> init_drive_lo_o)
    else $error("INIT not driven low on restart");

  p_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FINAL && !rs) |=> (clr_addr_o == '0 && state_q == ST_HOLD))
    else $error("final pass not aborted");

  p_no_start_low_init_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_INIT && !init_s) |=> !start_o)
    else $error("start while INIT low");

  p_mode_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rs) |=> $stable(mode_o))
    else $error("mode changed while ready");

  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o)
    else $error("start wider than one cycle");

  p_ready_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rs) |=> ready_o)
    else $error("ready dropped without restart");
endmodule

// File: tb/tb_cfg_start_seq.sv
module tb_cfg_start_seq;
  localparam int unsigned DEPTH = 12;
  localparam int unsigned AW    = 4;
  localparam int unsigned MW    = 3;
  localparam int unsigned WCYC  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart_n = 1'b1;
  logic ext_low = 1'b1;
  logic master = 1'b0;
  logic [MW-1:0] mode_in = '0;
  logic init_drv_lo, clr_we, start, ready;
  logic [AW-1:0] clr_addr;
  logic [MW-1:0] mode_out;
  logic init_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int run_len = 0, last_run = 0, zero_cnt = 0, contig_err = 0, start_cnt = 0;
  logic [AW-1:0] prev_addr = '0;
  logic prev_we = 1'b0;

  always #5 clk = ~clk;

  assign init_line = ~(init_drv_lo | ext_low);

  cfg_start_seq #(.CLR_DEPTH(DEPTH), .ADDR_W(AW), .MODE_W(MW), .WAIT_CYC(WCYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .restart_ni(restart_n), .init_sense_i(init_line),
    .master_i(master), .mode_i(mode_in), .init_drive_lo_o(init_drv_lo),
    .clr_we_o(clr_we), .clr_addr_o(clr_addr), .start_o(start), .ready_o(ready),
    .mode_o(mode_out)
  );

  // clear activity monitor
  always @(negedge clk) begin
    if (clr_we) begin
      if (clr_addr == 0) begin
        run_len = 1;
        zero_cnt++;
      end else if (prev_we && clr_addr == prev_addr + 1'b1) run_len++;
      else contig_err++;
      prev_addr = clr_addr;
    end else if (prev_we) last_run = run_len;
    prev_we = clr_we;
    if (start) start_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!start);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 ready", ready, 0);
    chk("R1 start", start, 0);
    chk("R1 mode", mode_out, 0);
    chk("R1 drive", init_drv_lo, 1);
    chk("R1 we", clr_we, 1);
    chk("R1 addr", clr_addr, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_init_hold;
    repeat (3 * DEPTH) @(negedge clk);
    chk("R4 pass length", last_run, DEPTH);
    chk("R4 contiguous", contig_err, 0);
    chk("R4 we off", clr_we, 0);
    chk("R6 drive released", init_drv_lo, 0);
    chk("R6 no ready", ready, 0);
    chk("R6 no start", start_cnt, 0);
  endtask

  task automatic t_slave_start;
    int n;
    mode_in = 3'd5;
    master = 1'b0;
    ext_low = 1'b0;
    wait_start(n);
    chk("R8 slave latency", n, 3);
    chk("R7 mode captured", mode_out, 5);
    chk("R10 ready with start", ready, 1);
    @(negedge clk);
    chk("R10 start one cycle", start, 0);
    chk("R10 ready held", ready, 1);
    mode_in = 3'd2;
    repeat (5) @(negedge clk);
    chk("R7 mode ignored", mode_out, 5);
  endtask

  task automatic t_restart_hold;
    int z0;
    ext_low = 1'b1;
    restart_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 drive low", init_drv_lo, 1);
    chk("R11 ready dropped", ready, 0);
    z0 = zero_cnt;
    repeat (3 * DEPTH) @(negedge clk);
    chk("R2 repeated sweeps", int'(zero_cnt - z0 >= 2), 1);
    chk("R2 still clearing", clr_we, 1);
    chk("R3 drive held", init_drv_lo, 1);
    chk("R2 contiguous", contig_err, 0);
  endtask

  task automatic t_abort;
    int z0;
    restart_n = 1'b1;
    repeat (4) @(negedge clk);
    while (!(clr_we && clr_addr == 4)) @(negedge clk);
    z0 = zero_cnt;
    restart_n = 1'b0;
    @(negedge clk);
    restart_n = 1'b1;
    repeat (4 * DEPTH) @(negedge clk);
    chk("R5 sweep restarted", int'(zero_cnt > z0), 1);
    chk("R5 full pass after abort", last_run, DEPTH);
    chk("R5 clearing ended", clr_we, 0);
    chk("R6 no ready while held", ready, 0);
  endtask

  task automatic t_collision;
    restart_n = 1'b0;
    repeat (3) @(negedge clk);
    restart_n = 1'b1;
    repeat (4) @(negedge clk);
    while (!(clr_we && clr_addr == AW'(DEPTH - 3))) @(negedge clk);
    restart_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 collision addr", clr_addr, 0);
    chk("R5 collision we", clr_we, 1);
    chk("R5 collision drive", init_drv_lo, 1);
    repeat (2) @(negedge clk);
    restart_n = 1'b1;
    repeat (4 * DEPTH) @(negedge clk);
    chk("R5 collision full pass", last_run, DEPTH);
    chk("R5 collision no start", ready, 0);
  endtask

  task automatic t_master;
    int n;
    mode_in = 3'd3;
    master = 1'b1;
    ext_low = 1'b0;
    wait_start(n);
    chk("R9 master latency", n, 3 + WCYC);
    chk("R7 master mode", mode_out, 3);
    @(negedge clk);
    chk("R10 master start one cycle", start, 0);
    chk("R10 master ready held", ready, 1);
  endtask

  task automatic t_restart_ready;
    restart_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 ready dropped", ready, 0);
    chk("R11 drive low", init_drv_lo, 1);
    chk("R11 clearing", clr_we, 1);
    restart_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_init_hold();
    t_slave_start();
    t_restart_hold();
    t_abort();
    t_collision();
    t_master();
    t_restart_ready();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule